// File: doc/BRIEF.md
# Interleaved Structure Transfer Sequencer

This block steps through every element access of a decoded multiple-structure vector load or store. A command gives the first target register, the base register number and its value, the element size, a quad flag that selects a full or half vector width, a repeat count, a structure-element count and post-index controls. The block then issues one memory request per element on a request/acknowledge port. Each request carries the vector register number, the lane, the byte address, the access size, the alignment size and the byte order.

The accesses follow an interleaved order. The structure-element index changes fastest, so consecutive accesses go to consecutive registers. When only one structure element is used and the data is little-endian, the per-element accesses are merged into 64-bit accesses. After the last acknowledge the block produces two kinds of follow-up traffic. For loads of half width it clears the upper half of each touched register. With post-indexing it writes back the base register. A one-cycle done pulse then ends the command.

A base register number of 31 selects the stack pointer. If that base is not 16-byte aligned, the command aborts before any memory access and reports an error flag. The register file and the memory sit outside the block.

Top module: `vstruct_seq`

## Requirements
- R1: After reset, mem_req, clr_valid, wb_valid, done, err and busy are all low.
- R2: Access k is ordered with the repeat index r outermost, the element index e next and the structure index s innermost. Its mem_reg is (rt + r + s) mod 32 and its mem_lane is e.
- R3: The first access uses the base value as its address. Each later address is the previous one plus 2^mem_size. Exactly rpt × selem × elements accesses are issued.
- R4: The number of elements per register is (16 if quad, else 8) >> access size. The access size is 2^size bytes.
- R5: mem_big is high only when big_endian is set and cmd_sz is not 0, because byte elements are always little-endian.
- R6: When cmd_selem is 1 and the access is little-endian, mem_size is 3 and the element count becomes (quad ? 2 : 1). mem_align always equals cmd_sz. Otherwise mem_size equals cmd_sz.
- R7: While mem_req is high and mem_ack is low, the request stays up with unchanged address, register and lane. The sequence advances only on an acknowledge.
- R8: For a load with quad clear, clr_valid is high for rpt × selem consecutive cycles, starting the cycle after the last acknowledge. clr_reg takes the values rt, rt+1, … mod 32. Stores and quad loads issue no clears.
- R9: With cmd_post set, wb_valid pulses once with wb_reg = cmd_rn. wb_value is base + total bytes (total = rpt × selem × (quad ? 16 : 8)) when cmd_rm is 31, and base + offset_val otherwise. The pulse falls in the cycle of the last clear, or in the cycle after the last acknowledge when there are no clears. Without cmd_post there is no pulse.
- R10: done is a one-cycle pulse in the cycle after the writeback slot.
- R11: If cmd_rn is 31 and base_val[3:0] is nonzero, no request is issued. err and done pulse together in the cycle after start. A misaligned base from any other register is accepted.
- R12: busy is high from the cycle after an accepted start until done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the command while idle |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_quad | input | 1 | Full-width (16-byte) registers |
| cmd_sz | input | 2 | log2 of element bytes |
| cmd_rpt | input | 3 | Repeat count (1..4) |
| cmd_selem | input | 3 | Structure elements (1..4) |
| cmd_rt | input | 5 | First target register |
| cmd_rn | input | 5 | Base register number (31 = stack pointer) |
| cmd_rm | input | 5 | Offset register number (31 = use total) |
| cmd_post | input | 1 | Post-index writeback enable |
| base_val | input | ADDR_W | Base register value |
| offset_val | input | ADDR_W | Offset register value |
| big_endian | input | 1 | Configured data byte order |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_ack | input | 1 | Memory acknowledge |
| mem_load | output | 1 | Request direction (1 = read) |
| mem_reg | output | 5 | Vector register of the access |
| mem_lane | output | 4 | Lane index in units of mem_size |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | log2 of access bytes |
| mem_align | output | 2 | log2 of required alignment |
| mem_big | output | 1 | Big-endian access |
| clr_valid | output | 1 | Clear upper half of clr_reg |
| clr_reg | output | 5 | Register to clear |
| wb_valid | output | 1 | Base writeback strobe |
| wb_reg | output | 5 | Register written back |
| wb_value | output | ADDR_W | New base value |
| done | output | 1 | Command finished |
| err | output | 1 | Stack-pointer alignment abort |

## Verification
The last upper-half clear and the base writeback can occur in the same cycle. This happens on every half-width load with post-indexing. Random and directed commands set both cmd_load and cmd_post with quad clear, and the bench records the cycle numbers of each clear, the writeback and done against the cycle of the final acknowledge. It then requires the writeback to sit on the last clear and done to follow one cycle later. Single-clear cases (rpt × selem = 1), where the clear, the writeback and the entry into the clear phase coincide, are included as a directed case.

// File: rtl/vstruct_pkg.sv
package vstruct_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACC  = 2'd1,
    S_CLR  = 2'd2,
    S_FIN  = 2'd3
  } vs_state_e;

  // merge into 64-bit accesses: one structure element and little-endian data
  function automatic logic merge_ok(input logic [2:0] selem, input logic [1:0] sz,
                                    input logic big);
    return (selem == 3'd1) && ((sz == 2'd0) || !big);
  endfunction

endpackage

// File: rtl/vstruct_plan.sv
module vstruct_plan #(
  parameter int VBYTES = 16,
  parameter int CNT_W  = 3,
  parameter int LANE_W = 4,
  parameter int TOT_W  = 11
) (
  input  logic              quad,
  input  logic [1:0]        sz,
  input  logic [CNT_W-1:0]  rpt,
  input  logic [CNT_W-1:0]  selem,
  input  logic              big_cfg,
  output logic [1:0]        eff_size,
  output logic [LANE_W:0]   elems,
  output logic              big,
  output logic [TOT_W-1:0]  total
);
  import vstruct_pkg::*;

  localparam int HALF = VBYTES / 2;
  localparam logic [1:0] WIDE_SZ = 2'($clog2(HALF));

  logic [LANE_W:0] reg_bytes;
  logic            merge;

  always_comb begin
    reg_bytes = quad ? (LANE_W+1)'(VBYTES) : (LANE_W+1)'(HALF);
    merge     = merge_ok(3'(selem), sz, big_cfg);
    eff_size  = merge ? WIDE_SZ : sz;
    elems     = reg_bytes >> eff_size;
    big       = big_cfg && (sz != 2'd0);
    total     = TOT_W'(rpt) * TOT_W'(selem) * TOT_W'(reg_bytes);
  end

endmodule

// File: rtl/vstruct_walk.sv
module vstruct_walk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int LANE_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [REG_W-1:0]  rt,
  input  logic [CNT_W-1:0]  rpt,
  input  logic [CNT_W-1:0]  selem,
  input  logic [LANE_W:0]   elems,
  input  logic [1:0]        esize,
  output logic [REG_W-1:0]  reg_idx,
  output logic [LANE_W-1:0] lane,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0]  rep_q, st_q;
  logic [LANE_W-1:0] lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic st_end, ln_end, rp_end;

  always_comb begin
    st_end  = (st_q == selem - 1'b1);
    ln_end  = ({1'b0, lane_q} == elems - 1'b1);
    rp_end  = (rep_q == rpt - 1'b1);
    last    = st_end && ln_end && rp_end;
    reg_idx = rt + REG_W'(rep_q) + REG_W'(st_q);
    lane    = lane_q;
    addr    = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q  <= '0;
      st_q   <= '0;
      lane_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      rep_q  <= '0;
      st_q   <= '0;
      lane_q <= '0;
      addr_q <= base;
    end else if (step) begin
      addr_q <= addr_q + (ADDR_W'(1) << esize);
      if (!st_end) begin
        st_q <= st_q + 1'b1;
      end else begin
        st_q <= '0;
        if (!ln_end) begin
          lane_q <= lane_q + 1'b1;
        end else begin
          lane_q <= '0;
          rep_q  <= rep_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vstruct_seq.sv
module vstruct_seq #(
  parameter int ADDR_W   = 32,
  parameter int NREG     = 32,
  parameter int VBYTES   = 16,
  parameter int CNT_W    = 3,
  parameter int SP_ALIGN = 16,
  localparam int REG_W   = $clog2(NREG),
  localparam int LANE_W  = $clog2(VBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmd_load,
  input  logic              cmd_quad,
  input  logic [1:0]        cmd_sz,
  input  logic [CNT_W-1:0]  cmd_rpt,
  input  logic [CNT_W-1:0]  cmd_selem,
  input  logic [REG_W-1:0]  cmd_rt,
  input  logic [REG_W-1:0]  cmd_rn,
  input  logic [REG_W-1:0]  cmd_rm,
  input  logic              cmd_post,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] offset_val,
  input  logic              big_endian,
  output logic              busy,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic              mem_load,
  output logic [REG_W-1:0]  mem_reg,
  output logic [LANE_W-1:0] mem_lane,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [1:0]        mem_align,
  output logic              mem_big,
  output logic              clr_valid,
  output logic [REG_W-1:0]  clr_reg,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_value,
  output logic              done,
  output logic              err
);
  import vstruct_pkg::*;

  localparam int SPA_W = $clog2(SP_ALIGN);
  localparam int TOT_W = 2 * CNT_W + LANE_W + 1;
  localparam int NC_W  = 2 * CNT_W;
  localparam logic [REG_W-1:0] SP_IDX = REG_W'(NREG - 1);

  vs_state_e state;

  logic              load_q, quad_q, post_q, big_q;
  logic [1:0]        sz_q;
  logic [CNT_W-1:0]  rpt_q, selem_q;
  logic [REG_W-1:0]  rt_q, rn_q, rm_q;
  logic [ADDR_W-1:0] base_q, off_q;
  logic [NC_W-1:0]   clr_left;

  logic [1:0]        eff_size;
  logic [LANE_W:0]   elems;
  logic              big_acc;
  logic [TOT_W-1:0]  total;
  logic              walk_last;
  logic              sp_bad, accept, step;
  logic [NC_W-1:0]   nclr;
  logic              need_clr;
  logic [ADDR_W-1:0] wb_next;

  vstruct_plan #(
    .VBYTES(VBYTES), .CNT_W(CNT_W), .LANE_W(LANE_W), .TOT_W(TOT_W)
  ) plan_i (
    .quad(quad_q), .sz(sz_q), .rpt(rpt_q), .selem(selem_q), .big_cfg(big_q),
    .eff_size(eff_size), .elems(elems), .big(big_acc), .total(total)
  );

  vstruct_walk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) walk_i (
    .clk(clk), .rst(rst), .load(accept), .step(step), .base(base_val),
    .rt(rt_q), .rpt(rpt_q), .selem(selem_q), .elems(elems), .esize(eff_size),
    .reg_idx(mem_reg), .lane(mem_lane), .addr(mem_addr), .last(walk_last)
  );

  always_comb begin
    sp_bad   = (cmd_rn == SP_IDX) && (base_val[SPA_W-1:0] != '0);
    accept   = (state == S_IDLE) && start && !sp_bad;
    step     = (state == S_ACC) && mem_ack;
    nclr     = NC_W'(rpt_q) * NC_W'(selem_q);
    need_clr = load_q && !quad_q;
    wb_next  = base_q + ((rm_q == SP_IDX) ? ADDR_W'(total) : off_q);
    busy     = (state != S_IDLE);
    mem_load = load_q;
    mem_size = eff_size;
    mem_align = sz_q;
    mem_big  = big_acc;
    wb_reg   = rn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      clr_valid <= 1'b0;
      clr_reg   <= '0;
      clr_left  <= '0;
      wb_valid  <= 1'b0;
      wb_value  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      load_q    <= 1'b0;
      quad_q    <= 1'b0;
      post_q    <= 1'b0;
      big_q     <= 1'b0;
      sz_q      <= '0;
      rpt_q     <= CNT_W'(1);
      selem_q   <= CNT_W'(1);
      rt_q      <= '0;
      rn_q      <= '0;
      rm_q      <= '0;
      base_q    <= '0;
      off_q     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          done <= 1'b0;
          err  <= 1'b0;
          if (start) begin
            load_q  <= cmd_load;
            quad_q  <= cmd_quad;
            post_q  <= cmd_post;
            big_q   <= big_endian;
            sz_q    <= cmd_sz;
            rpt_q   <= cmd_rpt;
            selem_q <= cmd_selem;
            rt_q    <= cmd_rt;
            rn_q    <= cmd_rn;
            rm_q    <= cmd_rm;
            base_q  <= base_val;
            off_q   <= offset_val;
            if (sp_bad) begin
              err  <= 1'b1;
              done <= 1'b1;
            end else begin
              mem_req <= 1'b1;
              state   <= S_ACC;
            end
          end
        end
        S_ACC: begin
          if (mem_ack && walk_last) begin
            mem_req  <= 1'b0;
            wb_value <= wb_next;
            if (need_clr) begin
              clr_valid <= 1'b1;
              clr_reg   <= rt_q;
              clr_left  <= nclr - 1'b1;
              wb_valid  <= post_q && (nclr == NC_W'(1));
              state     <= S_CLR;
            end else begin
              wb_valid <= post_q;
              state    <= S_FIN;
            end
          end
        end
        S_CLR: begin
          if (clr_left == '0) begin
            clr_valid <= 1'b0;
            wb_valid  <= 1'b0;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            clr_reg  <= clr_reg + 1'b1;
            clr_left <= clr_left - 1'b1;
            wb_valid <= post_q && (clr_left == NC_W'(1));
          end
        end
        default: begin
          wb_valid <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/vstruct_seq_chk.sv
module vstruct_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int LANE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [REG_W-1:0]  cmd_rn,
  input logic [ADDR_W-1:0] base_val,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [REG_W-1:0]  mem_reg,
  input logic [LANE_W-1:0] mem_lane,
  input logic              clr_valid,
  input logic [REG_W-1:0]  clr_reg,
  input logic              wb_valid,
  input logic              done,
  input logic              err
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_lane));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  wb_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done && !mem_req);

  // R11
  sp_abort_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (cmd_rn == '1) && (base_val[3:0] != 4'd0) |=> err && !mem_req && !busy);

  // R8
  clr_step_chk: assert property (@(posedge clk) disable iff (rst)
    clr_valid |=> (clr_valid && clr_reg == REG_W'($past(clr_reg) + 1'b1)) || (done && !clr_valid));

  // R8
  clr_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> !mem_req);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind vstruct_seq vstruct_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .cmd_rn(cmd_rn), .base_val(base_val),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_reg(mem_reg),
  .mem_lane(mem_lane), .clr_valid(clr_valid), .clr_reg(clr_reg), .wb_valid(wb_valid),
  .done(done), .err(err)
);

// File: tb/vstruct_seq_tb_top.sv
module vstruct_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 0, cmd_load = 0, cmd_quad = 0, cmd_post = 0, big_endian = 0;
  logic [1:0]  cmd_sz = 0;
  logic [2:0]  cmd_rpt = 1, cmd_selem = 1;
  logic [4:0]  cmd_rt = 0, cmd_rn = 0, cmd_rm = 0;
  logic [31:0] base_val = 0, offset_val = 0;
  logic        mem_ack = 0;
  logic        busy, mem_req, mem_load, mem_big, clr_valid, wb_valid, done, err;
  logic [4:0]  mem_reg, clr_reg, wb_reg;
  logic [3:0]  mem_lane;
  logic [31:0] mem_addr, wb_value;
  logic [1:0]  mem_size, mem_align;

  int nchk = 0;
  int nerr = 0;

  vstruct_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_load(cmd_load), .cmd_quad(cmd_quad),
    .cmd_sz(cmd_sz), .cmd_rpt(cmd_rpt), .cmd_selem(cmd_selem), .cmd_rt(cmd_rt),
    .cmd_rn(cmd_rn), .cmd_rm(cmd_rm), .cmd_post(cmd_post), .base_val(base_val),
    .offset_val(offset_val), .big_endian(big_endian), .busy(busy), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_load(mem_load), .mem_reg(mem_reg), .mem_lane(mem_lane),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_align(mem_align), .mem_big(mem_big),
    .clr_valid(clr_valid), .clr_reg(clr_reg), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_value(wb_value), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_esize(int sz, int selem, bit be);
    if (selem == 1 && (sz == 0 || !be)) return 3;
    return sz;
  endfunction

  task automatic run_cmd(input bit ld, input bit q, input int sz, input int rpt, input int selem,
                         input int rt, input int rn, input int rm, input bit post,
                         input logic [31:0] base, input logic [31:0] off, input bit be,
                         input bit poke);
    int esz, elems, nacc, idx, nclr, t, last_ack_t, last_clr_t, wb_t, done_t, nwb, slot, total;
    int er, ee, es;
    bit exp_err, ack, seen_done;
    logic [31:0] eaddr, exp_wb;
    esz   = exp_esize(sz, selem, be);
    elems = (q ? 16 : 8) >> esz;
    nacc  = rpt * selem * elems;
    total = rpt * selem * (q ? 16 : 8);
    exp_err = (rn == 31) && (base[3:0] != 0);
    exp_wb  = base + ((rm == 31) ? 32'(total) : off);
    cmd_load = ld; cmd_quad = q; cmd_sz = 2'(sz); cmd_rpt = 3'(rpt); cmd_selem = 3'(selem);
    cmd_rt = 5'(rt); cmd_rn = 5'(rn); cmd_rm = 5'(rm); cmd_post = post;
    base_val = base; offset_val = off; big_endian = be;
    start = 1;
    @(negedge clk);
    start = 0;
    idx = 0; nclr = 0; nwb = 0; t = 0; er = 0; ee = 0; es = 0; eaddr = base;
    last_ack_t = -1; last_clr_t = -1; wb_t = -1; done_t = -1; seen_done = 0;
    chk(busy == !exp_err, "R12", "busy after start", busy, !exp_err);
    while (!seen_done && t < 3000) begin
      ack = 0;
      if (mem_req) begin
        if (idx >= nacc) begin
          chk(0, "R3", "extra access", idx, nacc);
        end else begin
          chk(mem_reg == 5'((rt + er + es) % 32), "R2", "register", mem_reg, (rt + er + es) % 32);
          chk(mem_lane == 4'(ee), "R2", "lane", mem_lane, ee);
          chk(mem_addr == eaddr, "R3", "address", mem_addr, eaddr);
          chk(mem_size == 2'(esz), "R6", "access size", mem_size, esz);
          chk(mem_align == 2'(sz), "R6", "alignment", mem_align, sz);
          chk(mem_big == (be && sz != 0), "R5", "byte order", mem_big, be && sz != 0);
          chk(mem_load == ld, "R2", "direction", mem_load, ld);
          ack = ($urandom % 4) != 0;
          if (ack) begin
            idx++;
            eaddr = eaddr + (32'd1 << esz);
            if (es < selem - 1) es++;
            else begin
              es = 0;
              if (ee < elems - 1) ee++;
              else begin ee = 0; er++; end
            end
            if (idx == nacc) last_ack_t = t;
          end
        end
      end
      if (clr_valid) begin
        chk(clr_reg == 5'((rt + nclr) % 32), "R8", "clear register", clr_reg, (rt + nclr) % 32);
        nclr++;
        last_clr_t = t;
      end
      if (wb_valid) begin
        nwb++;
        wb_t = t;
        chk(wb_value == exp_wb, "R9", "writeback value", wb_value, exp_wb);
        chk(wb_reg == 5'(rn), "R9", "writeback register", wb_reg, rn);
      end
      if (done) begin
        seen_done = 1;
        done_t = t;
        chk(err == exp_err, "R11", "error flag", err, exp_err);
      end
      mem_ack = ack;
      if (poke && t == 1) begin
        start = 1;
        cmd_rt = 5'(rt + 7);
        base_val = base + 32'h100;
      end else begin
        start = 0;
      end
      @(negedge clk);
      t++;
    end
    mem_ack = 0;
    start = 0;
    chk(seen_done, "R10", "done seen", seen_done, 1);
    if (exp_err) begin
      chk(idx == 0, "R11", "accesses on abort", idx, 0);
      chk(done_t == 0, "R11", "abort timing", done_t, 0);
      chk(nwb == 0 && nclr == 0, "R11", "no follow-up on abort", nwb + nclr, 0);
    end else begin
      chk(idx == nacc, "R4", "access count", idx, nacc);
      chk(nclr == ((ld && !q) ? rpt * selem : 0), "R8", "clear count", nclr, (ld && !q) ? rpt * selem : 0);
      if (nclr > 0) begin
        chk(last_clr_t == last_ack_t + nclr, "R8", "clear timing", last_clr_t, last_ack_t + nclr);
        slot = last_clr_t;
      end else begin
        slot = last_ack_t + 1;
      end
      chk(nwb == (post ? 1 : 0), "R9", "writeback count", nwb, post);
      if (post) chk(wb_t == slot, "R9", "writeback timing", wb_t, slot);
      chk(done_t == slot + 1, "R10", "done timing", done_t, slot + 1);
    end
  endtask

  function automatic void pick_pair(int k, output int rpt, output int selem);
    case (k % 7)
      0: begin rpt = 1; selem = 4; end
      1: begin rpt = 4; selem = 1; end
      2: begin rpt = 1; selem = 3; end
      3: begin rpt = 3; selem = 1; end
      4: begin rpt = 1; selem = 1; end
      5: begin rpt = 1; selem = 2; end
      default: begin rpt = 2; selem = 1; end
    endcase
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog: done never reached");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !clr_valid && !wb_valid && !done && !err && !busy, "R1", "reset outputs",
        {mem_req, clr_valid, wb_valid, done, err, busy}, 0);
    // R11 misaligned stack pointer, R9/R8 suppressed
    run_cmd(1, 0, 2, 1, 4, 3, 31, 31, 1, 32'h0000_1008, 0, 0, 0);
    // R11 aligned stack pointer accepted
    run_cmd(1, 0, 2, 1, 2, 3, 31, 31, 1, 32'h0000_1000, 0, 0, 0);
    // R11 misaligned base from an ordinary register accepted
    run_cmd(0, 1, 1, 1, 3, 0, 4, 31, 1, 32'h0000_2003, 0, 1, 0);
    // R2 register wrap past 31
    run_cmd(1, 1, 3, 1, 4, 30, 2, 5, 1, 32'h0000_4000, 32'h40, 0, 0);
    // R6 promotion of bytes (always little-endian), quad -> two lanes
    run_cmd(1, 1, 0, 1, 1, 9, 1, 31, 1, 32'h0000_0101, 0, 1, 0);
    // R5/R6 big-endian halfwords, no promotion
    run_cmd(1, 0, 1, 1, 1, 9, 1, 31, 0, 32'h0000_0200, 0, 1, 0);
    // R8/R9 single clear coincides with writeback
    run_cmd(1, 0, 3, 1, 1, 17, 6, 31, 1, 32'h0000_0800, 0, 0, 0);
    // R12 start while busy ignored
    run_cmd(0, 0, 2, 2, 1, 12, 7, 8, 1, 32'h0000_3000, 32'hffff_fff0, 1, 1);
    // R9 offset register writeback with clears
    run_cmd(1, 0, 2, 3, 1, 28, 8, 2, 1, 32'h0000_5000, 32'h123, 1, 0);
    for (int n = 0; n < 60; n++) begin
      int rpt, selem, sz, rn;
      bit q;
      logic [31:0] base;
      pick_pair($urandom % 7, rpt, selem);
      sz = $urandom % 4;
      q = $urandom % 2;
      if (sz == 3 && selem != 1) q = 1;
      rn = ($urandom % 6 == 0) ? 31 : ($urandom % 31);
      base = $urandom;
      if (rn == 31 && ($urandom % 2)) base[3:0] = 0;
      run_cmd($urandom % 2, q, sz, rpt, selem, $urandom % 32, rn, ($urandom % 2) ? 31 : $urandom % 31,
              $urandom % 2, base, $urandom, $urandom % 2, ($urandom % 8) == 0);
    end
    summary();
  end

endmodule